// File: doc/BRIEF.md
# Fractional baud tick generator

This block turns a reference clock into the sampling-rate enable that a UART transmitter and receiver run from. The reference clock can first be divided by 1 or by 4. A 16-bit integer divisor and a 4-bit fraction in sixteenths then set the sample period. The fraction works by making some sample periods one counted step longer than others. A two-bit mode field sets the oversampling ratio to 16, 8 or 4. A second output marks every bit period.

Both outputs are one-clock-wide enables in the reference clock domain. They are not clocks, and they carry no handshake. The divisor and mode inputs are register values held steady by the surrounding logic. The block keeps its own copy of those values. Whenever a used bit of the inputs differs from that copy, the copy is updated and the divider restarts from a clean phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is active, both ticks are 0. The internal setting resets to integer divisor 1, fraction 0, 16x mode and divide-by-1. With the inputs held at int_lo=0x01, int_hi=0x00, frac_mode=0x00 and pre_div4=0, sample_tick is high on every clock after reset and bit_tick is high on every 16th clock.
- R2: The integer divisor N is {int_hi, int_lo}. With fraction 0 and pre_div4=0, sample_tick rises once every N clocks.
- R3: The fraction F is frac_mode[3:0]. Every sample period lasts N or N+1 counted steps. From the second period after a restart onward, every run of 16 consecutive periods adds up to 16*N+F steps.
- R4: When pre_div4=1, one counted step is 4 reference clocks, so all sample periods are four times longer. When pre_div4=0, one step is 1 clock.
- R5: frac_mode[5:4] selects the oversampling ratio: 00 gives 16, 01 gives 8, 10 gives 4, and 11 behaves as 16. bit_tick is high only together with sample_tick. After a restart it marks the sample ticks numbered R, 2R, 3R and so on, where R is the ratio.
- R6: frac_mode[7:6] has no effect. Changing these bits leaves the tick timing and phase untouched.
- R7: A change to any used input bit restarts the divider, the fraction phase and the oversampling count. The first sample_tick then comes exactly N*P clocks after the clock edge that takes in the change, where P is 1 or 4.
- R8: An integer divisor of 0 counts as 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_lo | input | 8 | Integer divisor, low byte |
| int_hi | input | 8 | Integer divisor, high byte |
| frac_mode | input | 8 | [3:0] fraction in sixteenths, [5:4] oversampling mode, [7:6] unused |
| pre_div4 | input | 1 | 1 divides the reference clock by 4 before the divisor |
| sample_tick | output | 1 | One-clock enable at the sampling rate |
| bit_tick | output | 1 | One-clock enable at the bit rate, aligned with sample_tick |

## Verification
Assertions check several things on every cycle. The divide-by-4 enable never pulses on two clocks in a row. The step counter never passes the stretched divisor. No period is stretched while the fraction is 0. A restart leaves the counter and the phase at zero. The oversampling count stays below its ratio, and bit_tick never appears without sample_tick. Other properties depend on stretched periods spread over many ticks, so only the bench scenarios can show them. These are the exact spacing after a restart, the 16-period sum set by the fraction, the factor of 4 from the prescaler, the bit-tick positions in each mode, the unused bits having no effect, and the zero-divisor period.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int OS_W = 5;

  typedef enum logic [1:0] {
    OS_X16  = 2'b00,
    OS_X8   = 2'b01,
    OS_X4   = 2'b10,
    OS_RSVD = 2'b11
  } os_mode_e;

  function automatic logic [OS_W-1:0] os_ratio(input os_mode_e m);
    case (m)
      OS_X8:   os_ratio = OS_W'(8);
      OS_X4:   os_ratio = OS_W'(4);
      default: os_ratio = OS_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel,
  output logic step_en
);
  localparam int PW = $clog2(PRE_DIV);

  logic [PW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (restart) pc_q <= '0;
    else if (pc_q == PW'(PRE_DIV-1)) pc_q <= '0;
    else              pc_q <= pc_q + PW'(1);
  end

  assign step_en = sel ? (pc_q == PW'(PRE_DIV-1)) : 1'b1;

  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && step_en && !restart) |=> !step_en);
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step_en,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac,
  output logic              period_end
);
  localparam int CW = INT_W + 1;

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     n_eff;
  logic [CW-1:0]     last_c;
  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic [FRAC_W:0]   sum_c;

  always_comb begin
    n_eff  = (int_div == '0) ? (CW'(1) << INT_W) : {1'b0, int_div};
    last_c = n_eff + CW'(ext_q) - CW'(1);
    sum_c  = {1'b0, acc_q} + {1'b0, frac};
  end

  assign period_end = step_en && !restart && (cnt_q == last_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (step_en) begin
      if (cnt_q == last_c) begin
        cnt_q <= '0;
        acc_q <= sum_c[FRAC_W-1:0];
        ext_q <= sum_c[FRAC_W];
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= n_eff);
  // R3
  no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frac == '0) |-> !ext_q);
  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && (acc_q == '0));
endmodule

// File: rtl/fbg_os_count.sv
module fbg_os_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] ratio,
  output logic             wrap
);
  logic [CNT_W-1:0] oc_q;

  assign wrap = step && (oc_q == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oc_q <= '0;
    else if (restart) oc_q <= '0;
    else if (wrap)    oc_q <= '0;
    else if (step)    oc_q <= oc_q + CNT_W'(1);
  end

  // R5
  os_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q < ratio);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FRAC_W  = 4,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] int_lo,
  input  logic [BYTE_W-1:0] int_hi,
  input  logic [BYTE_W-1:0] frac_mode,
  input  logic              pre_div4,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int INT_W = 2 * BYTE_W;
  localparam int FM_W  = FRAC_W + 2;

  logic [INT_W-1:0] idiv_q;
  logic [FM_W-1:0]  fm_q;
  logic             pre_q;
  logic             restart;
  logic             step_en;
  logic             period_end;
  logic             os_wrap;
  logic [OS_W-1:0]  ratio;
  logic [BYTE_W-FM_W-1:0] unused_fm_bits;

  assign unused_fm_bits = frac_mode[BYTE_W-1:FM_W];

  assign restart = ({int_hi, int_lo} != idiv_q) ||
                   (frac_mode[FM_W-1:0] != fm_q) ||
                   (pre_div4 != pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idiv_q <= INT_W'(1);
      fm_q   <= '0;
      pre_q  <= 1'b0;
    end else if (restart) begin
      idiv_q <= {int_hi, int_lo};
      fm_q   <= frac_mode[FM_W-1:0];
      pre_q  <= pre_div4;
    end
  end

  assign ratio = os_ratio(os_mode_e'(fm_q[FM_W-1:FRAC_W]));

  fbg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (pre_q),
    .step_en (step_en)
  );

  fbg_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .step_en    (step_en),
    .int_div    (idiv_q),
    .frac       (fm_q[FRAC_W-1:0]),
    .period_end (period_end)
  );

  fbg_os_count #(.CNT_W(OS_W)) u_os (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (period_end),
    .ratio   (ratio),
    .wrap    (os_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= period_end;
      bit_tick    <= os_wrap;
    end
  end

  // R5
  bit_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !sample_tick && !bit_tick);
endmodule

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] int_lo = 8'h01;
  logic [7:0] int_hi = 8'h00;
  logic [7:0] frac_mode = 8'h00;
  logic       pre_div4 = 1'b0;
  logic       sample_tick, bit_tick;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int stray_bits = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .int_lo(int_lo), .int_hi(int_hi),
    .frac_mode(frac_mode), .pre_div4(pre_div4),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] m);
    if (m == 2'b01) return 8;
    if (m == 2'b10) return 4;
    return 16;
  endfunction

  function automatic int eff_n(input logic [7:0] hi, input logic [7:0] lo);
    int v;
    v = {hi, lo};
    return (v == 0) ? 65536 : v;
  endfunction

  task automatic wait_tick(output int t, output bit b);
    @(negedge clk);
    while (!sample_tick) begin
      if (bit_tick) stray_bits++;
      @(negedge clk);
    end
    t = cyc;
    b = bit_tick;
  endtask

  // Apply a setting, check the first tick (R7) and then 16 further periods.
  task automatic run_cfg(input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] fr, input bit ps, input string tag);
    int tset, t, prev, per, sum, p, n, f, r;
    bit b;
    @(negedge clk);
    int_lo = lo; int_hi = hi; frac_mode = fr; pre_div4 = ps;
    tset = cyc;
    p = ps ? 4 : 1;
    n = eff_n(hi, lo);
    f = fr[3:0];
    r = ratio_of(fr[5:4]);
    wait_tick(t, b);
    chk(t - tset == 1 + n * p, "R7", "first tick delay", t - tset, 1 + n * p);
    chk(b == (r == 1), "R5", "bit tick on sample 1", b, r == 1);
    prev = t;
    sum = 0;
    for (int k = 2; k <= 17; k++) begin
      wait_tick(t, b);
      per = t - prev;
      prev = t;
      sum += per;
      chk(per == p * n || per == p * (n + 1), "R3", "period length", per, p * n);
      chk(b == ((k % r) == 0), "R5", "bit tick position", b, (k % r) == 0);
    end
    chk(sum == p * (16 * n + f), tag, "16-period sum", sum, p * (16 * n + f));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=finished", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t, t2, ns, nb;
    bit b;
    void'($urandom(32'd20240611));

    // R1: quiet during reset, then divisor 1 / 16x
    repeat (3) @(negedge clk);
    chk(!sample_tick && !bit_tick, "R1", "ticks in reset", sample_tick, 0);
    rst_n = 1'b1;
    ns = 0; nb = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ns += sample_tick;
      nb += bit_tick;
    end
    chk(ns == 32, "R1", "sample ticks in 32 clocks", ns, 32);
    chk(nb == 2, "R1", "bit ticks in 32 clocks", nb, 2);

    run_cfg(8'd10, 8'd0, 8'h00, 1'b0, "R2");
    run_cfg(8'h34, 8'h01, 8'h00, 1'b0, "R2");
    run_cfg(8'd7, 8'd0, 8'h05, 1'b0, "R3");
    run_cfg(8'd3, 8'd0, 8'h0F, 1'b1, "R4");
    run_cfg(8'd6, 8'd0, 8'h1B, 1'b0, "R5");
    run_cfg(8'd4, 8'd0, 8'h23, 1'b0, "R5");
    run_cfg(8'd4, 8'd0, 8'h33, 1'b1, "R5");

    // R6: toggling bits 7:6 right after a tick must not restart
    run_cfg(8'd5, 8'd0, 8'h00, 1'b0, "R6");
    frac_mode = 8'hC0;
    wait_tick(t2, b);
    chk(t2 - t >= 0, "R6", "tick seen", 1, 1);
    t = t2;
    frac_mode = 8'h40;
    wait_tick(t2, b);
    chk(t2 - t == 5, "R6", "period after unused-bit change", t2 - t, 5);

    for (int i = 0; i < 10; i++) begin
      logic [7:0] lo, fr;
      bit ps;
      lo = 8'(1 + ($urandom % 30));
      fr = 8'($urandom % 256);
      ps = 1'($urandom % 2);
      run_cfg(lo, 8'd0, fr, ps, "R3");
    end

    // R8: zero divisor counts as 65536
    @(negedge clk);
    int_lo = 8'd0; int_hi = 8'd0; frac_mode = 8'h00; pre_div4 = 1'b0;
    t = cyc;
    wait_tick(t2, b);
    chk(t2 - t == 65537, "R8", "zero divisor first tick", t2 - t, 65537);

    chk(stray_bits == 0, "R5", "bit ticks without sample tick", stray_bits, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule